// File: doc/BRIEF.md
# Two-Wire-Capable Synchronous Byte Shifter

This block moves one byte at a time over a clocked serial link. Software loads an 8-bit data register, then writes the control register with its start bit set. The block then shifts the byte out least significant bit first and, over the same eight clock periods, shifts the incoming bits into the same register, also least significant bit first. It can generate the shift clock itself from one of three divided rates of the system clock, or it can follow an external shift clock. A polarity bit sets the idle level of the shift clock. An input-switch bit turns the data-out pin into the data input, so that a half-duplex link needs only a clock wire and one data wire.

A status output stays high for the whole transfer. An interrupt flag rises in the same cycle that the status falls. The flag stays up until software acknowledges it or starts a new transfer.

Top module: `sio_shifter`

## Requirements
- R1: After reset: busy=0, irq=0, rd_data=0x00, rd_ctrl=0x00, sck_oe=1, sck_o=0 and so_oe=1.
- R2: A data write (wr_dat=1) while idle loads wdata into the data register, and rd_data shows it in the next cycle.
- R3: Control fields: bit0 is start, bits[2:1] are the clock select, bit3 is pol and bit4 is in_sw. A control write with bit0=1 while idle raises busy in the next cycle. Start always reads back as 0, and rd_ctrl bits[7:5] read 0.
- R4: One transfer sends the loaded byte on so_o, LSB first. It leaves the eight received bits in rd_data, with the first received bit in bit0.
- R5: Clock select 0, 1 and 2 uses the internal clock, which toggles every DIV0, DIV1 or DIV2 system cycles. In these modes sck_oe=1, and sck_o rests at pol whenever the block is idle. A whole transfer lasts 16 half periods, counted from the start write to the fall of busy.
- R6: A leading SCK edge (moving away from pol) is the only event that changes so_o. A trailing SCK edge (moving back to pol) samples the input bit.
- R7: Clock select 3 uses the external clock: sck_oe=0, and shifting follows the edges of sck_i after synchronization, with the same leading and trailing roles.
- R8: With in_sw=1, so_oe=0 and received bits come from so_i. si_i has no effect.
- R9: busy falls and irq rises on the same clock edge, namely the edge that handles the eighth trailing SCK edge.
- R10: irq clears on irq_ack or on an accepted start. If completion and irq_ack fall in the same cycle, irq ends up set.
- R11: While busy, data writes and control writes are ignored. rd_ctrl and the transfer in progress stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_dat | input | 1 | Write strobe for the data register |
| wr_ctrl | input | 1 | Write strobe for the control register |
| wdata | input | 8 | Write data |
| irq_ack | input | 1 | Clears the interrupt flag |
| sck_i | input | 1 | External shift clock |
| si_i | input | 1 | Serial data input pin |
| so_i | input | 1 | Level read back from the data-out pin |
| rd_data | output | 8 | Data register contents |
| rd_ctrl | output | 8 | Control register readback |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Transfer-complete interrupt flag |
| sck_o | output | 1 | Internally generated shift clock |
| sck_oe | output | 1 | Output enable for the shift clock pin |
| so_o | output | 1 | Serial data output |
| so_oe | output | 1 | Output enable for the data-out pin |

## Verification
Two events can land in the same clock cycle. The first is the completion of a transfer, where the final trailing edge sets irq and drops busy. The second is a software action in the same cycle: an irq_ack, or a data-register write that arrives while busy is still high. The bench uses the fastest internal rate. It counts exactly 16 half periods from the start edge and drives both irq_ack and a data write into the cycle just before the final edge. Afterwards it expects irq to be set, busy to be low, and the data register to hold the received byte rather than the written one.

// File: rtl/sio_shifter.sv
`timescale 1ns/1ps
module sio_shifter #(
  parameter int DIV0 = 2,
  parameter int DIV1 = 4,
  parameter int DIV2 = 8
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_dat,
  input  logic       wr_ctrl,
  input  logic [7:0] wdata,
  input  logic       irq_ack,
  input  logic       sck_i,
  input  logic       si_i,
  input  logic       so_i,
  output logic [7:0] rd_data,
  output logic [7:0] rd_ctrl,
  output logic       busy,
  output logic       irq,
  output logic       sck_o,
  output logic       sck_oe,
  output logic       so_o,
  output logic       so_oe
);
  localparam int DMAX = (DIV0 > DIV1) ? ((DIV0 > DIV2) ? DIV0 : DIV2)
                                      : ((DIV1 > DIV2) ? DIV1 : DIV2);
  localparam int CW = $clog2(DMAX) + 1;

  logic [7:0]    sreg;
  logic [1:0]    csel;
  logic          pol, insw, busy_q, irq_q, sck_q, so_q;
  logic [2:0]    bcnt;
  logic [CW-1:0] hcnt, hp;
  logic          s1, s2, s3;
  logic          ext, tick, xedge, lead, trail, din, start_ok, done;

  always_comb begin
    case (csel)
      2'd0:    hp = CW'(DIV0);
      2'd1:    hp = CW'(DIV1);
      default: hp = CW'(DIV2);
    endcase
  end

  assign ext      = (csel == 2'b11);
  assign tick     = busy_q && !ext && (hcnt == hp - CW'(1));
  assign xedge    = busy_q && ext && (s2 != s3);
  assign lead     = (tick && (sck_q == pol)) || (xedge && (s2 != pol));
  assign trail    = (tick && (sck_q != pol)) || (xedge && (s2 == pol));
  assign din      = insw ? so_i : si_i;
  assign start_ok = wr_ctrl && wdata[0] && !busy_q;
  assign done     = trail && (bcnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg   <= '0;
      csel   <= '0;
      pol    <= 1'b0;
      insw   <= 1'b0;
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      sck_q  <= 1'b0;
      so_q   <= 1'b0;
      bcnt   <= '0;
      hcnt   <= '0;
      s1     <= 1'b0;
      s2     <= 1'b0;
      s3     <= 1'b0;
    end else begin
      s1 <= sck_i;
      s2 <= s1;
      s3 <= s2;

      if (wr_ctrl && !busy_q) begin
        csel <= wdata[2:1];
        pol  <= wdata[3];
        insw <= wdata[4];
      end

      if (wr_dat && !busy_q) sreg <= wdata;
      else if (trail)        sreg <= {din, sreg[7:1]};

      if (lead) so_q <= sreg[0];

      if (start_ok) begin
        busy_q <= 1'b1;
        bcnt   <= '0;
      end else if (trail) begin
        bcnt <= bcnt + 3'd1;
        if (done) busy_q <= 1'b0;
      end

      if (done)                     irq_q <= 1'b1;
      else if (irq_ack || start_ok) irq_q <= 1'b0;

      if (!busy_q || tick) hcnt <= '0;
      else                 hcnt <= hcnt + CW'(1);

      if (!busy_q)   sck_q <= wr_ctrl ? wdata[3] : pol;
      else if (tick) sck_q <= ~sck_q;
    end
  end

  assign rd_data = sreg;
  assign rd_ctrl = {3'b000, insw, pol, csel, 1'b0};
  assign busy    = busy_q;
  assign irq     = irq_q;
  assign sck_o   = sck_q;
  assign sck_oe  = !ext;
  assign so_o    = so_q;
  assign so_oe   = !insw;
endmodule

// File: rtl/sio_shifter_chk.sv
`timescale 1ns/1ps
module sio_shifter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_ctrl,
  input logic [7:0] wdata,
  input logic       irq_ack,
  input logic       busy,
  input logic       irq,
  input logic [7:0] rd_ctrl,
  input logic       sck_o,
  input logic       sck_oe
);
  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[0] && !busy) |=> busy);

  // R9
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(busy));

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !busy) |=> !irq);

  // R11
  frozen_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(rd_ctrl));

  // R5
  idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sck_oe) |-> (sck_o == rd_ctrl[3]));
endmodule

bind sio_shifter sio_shifter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(wdata),
  .irq_ack(irq_ack), .busy(busy), .irq(irq), .rd_ctrl(rd_ctrl),
  .sck_o(sck_o), .sck_oe(sck_oe)
);

// File: tb/tb_sio_shifter.sv
`timescale 1ns/1ps
module tb_sio_shifter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_dat = 1'b0, wr_ctrl = 1'b0, irq_ack = 1'b0;
  logic [7:0] wdata = '0;
  logic       sck_i = 1'b0, si_i = 1'b0, so_i = 1'b0;
  logic [7:0] rd_data, rd_ctrl;
  logic       busy, irq, sck_o, sck_oe, so_o, so_oe;
  int         tests = 0, fails = 0;

  always #4 clk = ~clk;

  sio_shifter dut (
    .clk(clk), .rst_n(rst_n), .wr_dat(wr_dat), .wr_ctrl(wr_ctrl), .wdata(wdata),
    .irq_ack(irq_ack), .sck_i(sck_i), .si_i(si_i), .so_i(so_i),
    .rd_data(rd_data), .rd_ctrl(rd_ctrl), .busy(busy), .irq(irq),
    .sck_o(sck_o), .sck_oe(sck_oe), .so_o(so_o), .so_oe(so_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] b);
    @(negedge clk); wr_dat = 1'b1; wdata = b;
    @(negedge clk); wr_dat = 1'b0;
  endtask

  task automatic start(input logic [7:0] c);
    @(negedge clk); wr_ctrl = 1'b1; wdata = c;
    @(posedge clk);
    @(negedge clk); wr_ctrl = 1'b0;
    chk(busy == 1'b1, "R3 busy after start", busy, 1);
    chk(rd_ctrl == {3'b000, c[4:1], 1'b0}, "R3 ctrl readback", rd_ctrl, {3'b000, c[4:1], 1'b0});
  endtask

  task automatic t_reset;
    chk(busy == 0 && irq == 0, "R1 busy/irq", {busy, irq}, 0);
    chk(rd_data == 8'h00 && rd_ctrl == 8'h00, "R1 registers", {rd_data, rd_ctrl}, 0);
    chk(sck_oe == 1 && sck_o == 0 && so_oe == 1, "R1 pins", {sck_oe, sck_o, so_oe}, 3'b101);
  endtask

  task automatic t_load;
    load(8'hC3);
    chk(rd_data == 8'hC3, "R2 data load", rd_data, 8'hC3);
  endtask

  task automatic t_int(input logic [1:0] sel, input logic p, input logic sw,
                       input logic [7:0] tx, input logic [7:0] rx);
    int hp, n, li, ti;
    logic prev;
    logic [7:0] cap;
    hp = (sel == 0) ? 2 : (sel == 1) ? 4 : 8;
    load(tx);
    start({3'b000, sw, p, sel, 1'b1});
    prev = p; n = 0; li = 0; ti = 0; cap = '0;
    chk(so_oe == !sw, "R8 so_oe", so_oe, !sw);
    while (busy && n < 5000) begin
      @(posedge clk); @(negedge clk); n++;
      if (sck_o != prev) begin
        if (sck_o != p) begin
          if (li < 8) begin
            si_i = sw ? ~rx[li] : rx[li];
            so_i = sw ? rx[li] : ~rx[li];
          end
          li++;
        end else begin
          if (ti < 8) cap[ti] = so_o;
          ti++;
        end
        prev = sck_o;
      end
    end
    chk(n == 16 * hp, "R5 transfer length", n, 16 * hp);
    chk(cap == tx, "R4 R6 transmitted bits", cap, tx);
    chk(rd_data == rx, sw ? "R8 received via so_i" : "R4 received byte", rd_data, rx);
    chk(irq == 1, "R9 irq at completion", irq, 1);
    @(negedge clk);
    chk(sck_o == p && sck_oe == 1, "R5 idle clock level", sck_o, p);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic t_ext(input logic p, input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] cap;
    sck_i = p;
    repeat (5) @(negedge clk);
    load(tx);
    start({3'b000, 1'b0, p, 2'b11, 1'b1});
    chk(sck_oe == 0, "R7 sck_oe low", sck_oe, 0);
    cap = '0;
    for (int b = 0; b < 8; b++) begin
      sck_i = ~p; si_i = rx[b];
      repeat (6) @(negedge clk);
      cap[b] = so_o;
      sck_i = p;
      repeat (6) @(negedge clk);
    end
    chk(busy == 0 && irq == 1, "R7 R9 external completion", {busy, irq}, 2'b01);
    chk(cap == tx, "R7 external transmit", cap, tx);
    chk(rd_data == rx, "R7 external receive", rd_data, rx);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic t_busy_writes;
    int n;
    si_i = 1'b1;
    load(8'h00);
    start(8'h03);
    repeat (10) @(negedge clk);
    wr_dat = 1'b1; wr_ctrl = 1'b1; wdata = 8'h1E;
    @(negedge clk); wr_dat = 1'b0; wr_ctrl = 1'b0;
    chk(rd_ctrl == 8'h02 && sck_oe == 1, "R11 ctrl write ignored", rd_ctrl, 8'h02);
    n = 11;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk(n == 64, "R11 transfer undisturbed", n, 64);
    chk(rd_data == 8'hFF, "R11 data write ignored", rd_data, 8'hFF);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic t_collision;
    int n;
    si_i = 1'b1;
    load(8'h55);
    start(8'h01);
    repeat (31) @(negedge clk);
    chk(busy == 1, "R9 still busy before last edge", busy, 1);
    irq_ack = 1'b1; wr_dat = 1'b1; wdata = 8'h00;
    @(negedge clk);
    irq_ack = 1'b0; wr_dat = 1'b0;
    chk(irq == 1 && busy == 0, "R10 set wins over ack", {irq, busy}, 2'b10);
    chk(rd_data == 8'hFF, "R11 write at last edge ignored", rd_data, 8'hFF);
    start(8'h01);
    chk(irq == 0, "R10 start clears irq", irq, 0);
    n = 1;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk(irq == 1, "R9 irq set again", irq, 1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk(irq == 0, "R10 ack clears irq", irq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_int(2'd0, 1'b0, 1'b0, 8'hA5, 8'h3C);
    t_int(2'd1, 1'b1, 1'b0, 8'h81, 8'h7E);
    t_int(2'd2, 1'b0, 1'b1, 8'h5B, 8'hC6);
    t_ext(1'b1, 8'h96, 8'h2D);
    t_ext(1'b0, 8'h4E, 8'hB1);
    t_busy_writes();
    t_collision();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule